// File: doc/BRIEF.md
# Network Port Mode Selector

This block holds the medium-selection and physical-layer option settings of a 10 Mb/s Ethernet controller and decides which of three network ports is active: the attachment-unit port (AUI), the twisted-pair port, or a general-purpose serial port. Software writes a small configuration word through a plain register write port. The write takes effect only while the controller reports that it is stopped. Software can read the stored word back at any time.

A two-bit port code in the word picks the port. When an external auto-select enable is high, the choice between the AUI and twisted-pair codes no longer comes from software. The block takes it from the live twisted-pair link status instead. That status is first passed through a synchronizer. The active port is held in a registered state machine with four states: `PORT_AUI`, `PORT_TP`, `PORT_SERIAL` and `PORT_RSVD`. The machine moves on every clock to the state that the current port code, auto-select enable and synchronized link status decode to. There is no other sequencing. Any state can go to any other state in one step.

The option bits are gated by the active port before they reach the outputs:
- The receive-threshold option and the polarity-correction-disable option are driven out only while the twisted-pair port is active.
- The idle-level option is driven out only while the AUI port is active.

Top module: `netport_mode_sel`

## Requirements
- R1: With auto-select low, the port code in `wr_data[1:0]` selects the port as follows, and exactly one of the four outputs is high:
  - 00 selects AUI (`en_aui`).
  - 01 selects twisted pair (`en_tp`).
  - 10 selects the serial port (`en_serial`).
  - 11 asserts `rsvd_code` with no port enable.
- R2: With auto-select high and port code bit 1 low, the twisted-pair port is selected when the synchronized link passes. AUI is selected when it fails. The written bit 0 is ignored.
- R3: With auto-select high, code 10 still selects the serial port and code 11 still reports reserved.
- R4: With auto-select low, the link status input has no effect on the active port.
- R5: A write (`wr_en` high) updates the stored word only while `stop_i` is high. Otherwise the stored word is unchanged. The stored word layout is:
  - bit 0–1: port code
  - bit 2: receive-threshold option
  - bit 3: idle-level option
  - bit 4: polarity-correction-disable option
- R6: The stored word clears to zero on the asynchronous hard reset (`hard_rst_n` low) or on a synchronous soft reset (`soft_rst` high at a clock edge). Changing `stop_i` does not alter it. After a hard reset the AUI port is active.
- R7: `lrt_o` and `pol_dis_o` follow their stored bits only while the twisted-pair port is active, and are low otherwise.
- R8: `tsel_o` follows its stored bit only while the AUI port is active, and is low otherwise.
- R9: A write that changes the port code changes the port outputs at the clock edge after the edge that stores the write, not earlier.
- R10: `rd_data` returns the stored word whatever the value of `stop_i`.
- R11: A change of `link_pass_i` with auto-select high reaches the port outputs on the third rising edge after it is applied: two synchronizer edges and one state edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous active-high soft reset of the stored word |
| stop_i | input | 1 | Controller-stopped status; enables writes |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 5 | Write data (layout in R5) |
| rd_data | output | 5 | Stored configuration word |
| auto_sel_i | input | 1 | Auto-select enable |
| link_pass_i | input | 1 | Asynchronous twisted-pair link status, 1 = pass |
| en_aui | output | 1 | AUI port active |
| en_tp | output | 1 | Twisted-pair port active |
| en_serial | output | 1 | Serial port active |
| rsvd_code | output | 1 | Reserved port code in use |
| lrt_o | output | 1 | Gated receive-threshold option |
| tsel_o | output | 1 | Gated idle-level option |
| pol_dis_o | output | 1 | Gated polarity-correction-disable option |

## Verification
The hardest case is a link-status change that arrives while auto-select is high and the port code is 00 or 01. Its effect shows only after the synchronizer delay, and a refused write in the same window must not disturb it. A directed sequence holds the port code in auto mode and toggles the link. It samples the port outputs after the second and after the third edge to pin the exact latency. Random rounds then mix stop-gated writes, auto-select changes and link changes, and let each settle before comparing all outputs against a bench model of the decode.

// File: rtl/nps_pkg.sv
package nps_pkg;
    localparam int CFG_W      = 5;
    localparam int PSEL_LSB   = 0;
    localparam int LRT_BIT    = 2;
    localparam int TSEL_BIT   = 3;
    localparam int POLDIS_BIT = 4;

    typedef enum logic [1:0] {
        PORT_AUI    = 2'b00,
        PORT_TP     = 2'b01,
        PORT_SERIAL = 2'b10,
        PORT_RSVD   = 2'b11
    } port_state_e;
endpackage

// File: rtl/nps_cfg_reg.sv
module nps_cfg_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         hard_rst_n,
    input  logic         soft_rst,
    input  logic         stop_i,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cfg_q
);
    always_ff @(posedge clk or negedge hard_rst_n) begin
        if (!hard_rst_n) begin
            cfg_q <= '0;
        end else if (soft_rst) begin
            cfg_q <= '0;
        end else if (wr_en && stop_i) begin
            cfg_q <= wr_data;
        end
    end

    // R5: running controller refuses writes
    p_write_blocked_r5: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (!stop_i && !soft_rst) |=> $stable(cfg_q));

    // R6: soft reset clears the stored word
    p_soft_clear_r6: assert property (@(posedge clk) disable iff (!hard_rst_n)
        soft_rst |=> (cfg_q == '0));
endmodule

// File: rtl/nps_link_sync.sv
module nps_link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic hard_rst_n,
    input  logic async_i,
    output logic sync_o
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;
    logic [N-1:0] chain_q;

    generate
        for (genvar s = 0; s < N; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge hard_rst_n) begin
                    if (!hard_rst_n) chain_q[0] <= 1'b0;
                    else             chain_q[0] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge hard_rst_n) begin
                    if (!hard_rst_n) chain_q[s] <= 1'b0;
                    else             chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[N-1];
endmodule

// File: rtl/nps_port_fsm.sv
module nps_port_fsm
    import nps_pkg::*;
(
    input  logic       clk,
    input  logic       hard_rst_n,
    input  logic [1:0] psel,
    input  logic       auto_sel,
    input  logic       link_ok,
    output logic       en_aui,
    output logic       en_tp,
    output logic       en_serial,
    output logic       rsvd
);
    port_state_e state_q, state_d;

    // next state: direct decode of the code, auto-select and link status
    always_comb begin
        state_d = PORT_AUI;
        unique case (psel)
            2'b00:   state_d = (auto_sel && link_ok) ? PORT_TP : PORT_AUI;
            2'b01:   state_d = (auto_sel && !link_ok) ? PORT_AUI : PORT_TP;
            2'b10:   state_d = PORT_SERIAL;
            default: state_d = PORT_RSVD;
        endcase
    end

    always_ff @(posedge clk or negedge hard_rst_n) begin
        if (!hard_rst_n) state_q <= PORT_AUI;
        else             state_q <= state_d;
    end

    always_comb begin
        en_aui    = 1'b0;
        en_tp     = 1'b0;
        en_serial = 1'b0;
        rsvd      = 1'b0;
        unique case (state_q)
            PORT_AUI:    en_aui    = 1'b1;
            PORT_TP:     en_tp     = 1'b1;
            PORT_SERIAL: en_serial = 1'b1;
            PORT_RSVD:   rsvd      = 1'b1;
            default:     rsvd      = 1'b1;
        endcase
    end

    // R1: one active indication at all times
    p_one_port_r1: assert property (@(posedge clk) disable iff (!hard_rst_n)
        $onehot({en_aui, en_tp, en_serial, rsvd}));
endmodule

// File: rtl/netport_mode_sel.sv
module netport_mode_sel
    import nps_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             hard_rst_n,
    input  logic             soft_rst,
    input  logic             stop_i,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    input  logic             auto_sel_i,
    input  logic             link_pass_i,
    output logic             en_aui,
    output logic             en_tp,
    output logic             en_serial,
    output logic             rsvd_code,
    output logic             lrt_o,
    output logic             tsel_o,
    output logic             pol_dis_o
);
    logic [CFG_W-1:0] cfg_q;
    logic             link_s;

    nps_cfg_reg #(.W(CFG_W)) u_cfg (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .soft_rst   (soft_rst),
        .stop_i     (stop_i),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cfg_q      (cfg_q)
    );

    nps_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .async_i    (link_pass_i),
        .sync_o     (link_s)
    );

    nps_port_fsm u_fsm (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .psel       (cfg_q[PSEL_LSB +: 2]),
        .auto_sel   (auto_sel_i),
        .link_ok    (link_s),
        .en_aui     (en_aui),
        .en_tp      (en_tp),
        .en_serial  (en_serial),
        .rsvd       (rsvd_code)
    );

    assign rd_data   = cfg_q;
    assign lrt_o     = en_tp  & cfg_q[LRT_BIT];
    assign pol_dis_o = en_tp  & cfg_q[POLDIS_BIT];
    assign tsel_o    = en_aui & cfg_q[TSEL_BIT];

    // R7: twisted-pair options only on twisted pair
    p_tp_gate_r7: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (lrt_o || pol_dis_o) |-> en_tp);

    // R8: idle-level option only on AUI
    p_aui_gate_r8: assert property (@(posedge clk) disable iff (!hard_rst_n)
        tsel_o |-> en_aui);

    // R3: serial code wins regardless of auto-select
    p_serial_code_r3: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (cfg_q[PSEL_LSB +: 2] == 2'b10) |=> en_serial);
endmodule

// File: tb/netport_mode_sel_tb_top.sv
module netport_mode_sel_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       hard_rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       stop_i = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_data = '0;
    logic [4:0] rd_data;
    logic       auto_sel_i = 1'b0;
    logic       link_pass_i = 1'b0;
    logic       en_aui, en_tp, en_serial, rsvd_code, lrt_o, tsel_o, pol_dis_o;

    int checks = 0;
    int failures = 0;
    logic [4:0] m_cfg = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    netport_mode_sel dut_i (
        .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst(soft_rst), .stop_i(stop_i),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .auto_sel_i(auto_sel_i), .link_pass_i(link_pass_i),
        .en_aui(en_aui), .en_tp(en_tp), .en_serial(en_serial), .rsvd_code(rsvd_code),
        .lrt_o(lrt_o), .tsel_o(tsel_o), .pol_dis_o(pol_dis_o)
    );

    // {en_serial, en_tp, en_aui, rsvd}
    function automatic logic [3:0] exp_ports(logic [1:0] code, logic aut, logic lnk);
        case (code)
            2'b00:   return (aut && lnk)  ? 4'b0100 : 4'b0010;
            2'b01:   return (aut && !lnk) ? 4'b0010 : 4'b0100;
            2'b10:   return 4'b1000;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic logic [2:0] exp_opts(logic [4:0] c, logic [3:0] p);
        // {pol_dis, tsel, lrt}
        return {c[4] & p[2], c[3] & p[1], c[2] & p[2]};
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (hard_rst_n && soft_rst) m_cfg = '0;
        else if (hard_rst_n && wr_en && stop_i) m_cfg = wr_data;
        @(negedge clk);
    endtask

    task automatic check_ports(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {en_serial, en_tp, en_aui, rsvd_code};
        check(act == exp, req, {28'd0, act}, {28'd0, exp});
    endtask

    task automatic check_all(input string req);
        logic [3:0] p;
        logic [2:0] o;
        p = exp_ports(m_cfg[1:0], auto_sel_i, link_pass_i);
        o = exp_opts(m_cfg, p);
        check_ports(req, p);
        check({pol_dis_o, tsel_o, lrt_o} == o, req, {29'd0, pol_dis_o, tsel_o, lrt_o}, {29'd0, o});
        check(rd_data == m_cfg, req, {27'd0, rd_data}, {27'd0, m_cfg});
    endtask

    task automatic do_write(input logic [4:0] d, input logic stp);
        stop_i = stp; wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [3:0] prev;
        @(negedge clk);
        tick();
        // R6: hard reset state
        check(rd_data == 5'd0, "R6 reset word", {27'd0, rd_data}, 0);
        check_ports("R6 reset port AUI", 4'b0010);
        hard_rst_n = 1'b1;
        tick();

        // R5: refused write while running
        do_write(5'h1D, 1'b0);
        check(rd_data == 5'd0, "R5 write refused", {27'd0, rd_data}, 0);

        // R9: twisted pair plus options, one-cycle lag
        do_write(5'b10101, 1'b1);
        check(rd_data == 5'b10101, "R10 read after write", {27'd0, rd_data}, 5'b10101);
        check_ports("R9 old port held", 4'b0010);
        tick();
        check_ports("R9 new port", 4'b0100);
        check({pol_dis_o, lrt_o} == 2'b11, "R7 tp options", {30'd0, pol_dis_o, lrt_o}, 3);

        // R10/R6: stop change leaves word, read regardless of stop
        stop_i = 1'b0; tick(); tick();
        check(rd_data == 5'b10101, "R10 read with stop low", {27'd0, rd_data}, 5'b10101);

        // R1: serial and reserved codes
        do_write(5'b11110, 1'b1); tick();
        check_ports("R1 serial", 4'b1000);
        check({pol_dis_o, tsel_o, lrt_o} == 3'b000, "R7 options gated on serial", {29'd0, pol_dis_o, tsel_o, lrt_o}, 0);
        do_write(5'b11111, 1'b1); tick();
        check_ports("R1 reserved", 4'b0001);
        check({pol_dis_o, tsel_o, lrt_o} == 3'b000, "R8 options gated on reserved", {29'd0, pol_dis_o, tsel_o, lrt_o}, 0);

        // R8: idle-level option on AUI, gone on TP
        do_write(5'b01000, 1'b1); tick();
        check(tsel_o == 1'b1, "R8 tsel on AUI", {31'd0, tsel_o}, 1);
        do_write(5'b01001, 1'b1); tick();
        check(tsel_o == 1'b0, "R8 tsel off on TP", {31'd0, tsel_o}, 0);

        // R11/R2: link latency in auto mode
        do_write(5'b00000, 1'b1);
        auto_sel_i = 1'b1; link_pass_i = 1'b0;
        repeat (4) tick();
        check_ports("R2 auto link fail AUI", 4'b0010);
        link_pass_i = 1'b1;
        tick(); tick();
        check_ports("R11 not yet after two edges", 4'b0010);
        tick();
        check_ports("R11 third edge TP", 4'b0100);
        // R2: written TP ignored on link fail
        do_write(5'b00001, 1'b1);
        link_pass_i = 1'b0;
        repeat (4) tick();
        check_ports("R2 code 01 link fail AUI", 4'b0010);
        // R3: auto with serial/reserved
        do_write(5'b00010, 1'b1); link_pass_i = 1'b1; repeat (4) tick();
        check_ports("R3 auto serial", 4'b1000);
        do_write(5'b00011, 1'b1); repeat (4) tick();
        check_ports("R3 auto reserved", 4'b0001);
        // R4: link ignored without auto
        auto_sel_i = 1'b0;
        do_write(5'b00000, 1'b1); repeat (4) tick();
        check_ports("R4 manual AUI link pass", 4'b0010);
        link_pass_i = 1'b0; repeat (4) tick();
        check_ports("R4 manual AUI link fail", 4'b0010);

        // R6: soft reset
        do_write(5'b11101, 1'b1);
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        check(rd_data == 5'd0, "R6 soft reset clears", {27'd0, rd_data}, 0);

        // random rounds
        void'($urandom(32'd2024));
        for (int i = 0; i < 300; i++) begin
            stop_i      = $urandom_range(0, 1);
            wr_en       = $urandom_range(0, 3) != 0;
            wr_data     = 5'($urandom);
            auto_sel_i  = $urandom_range(0, 1);
            link_pass_i = $urandom_range(0, 1);
            soft_rst    = ($urandom_range(0, 15) == 0);
            tick();
            wr_en = 1'b0; soft_rst = 1'b0;
            stop_i = $urandom_range(0, 1);
            repeat (4) tick();
            check_all("R1 R2 R3 R4 R5 R7 R8 R10 random");
        end

        done = 1;
        prev = 0;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule